// File: doc/BRIEF.md
# Two-Wire Slave Shift Unit with Clock Hold

This block is the bit-level front end of a two-wire (I2C-style) bus slave. It samples the open-drain clock and data lines with the system clock, recognises start and stop conditions, and shifts received bits into a serial register on clock rising edges. A small edge counter sees every clock edge, so a full byte is sixteen edges. Outgoing bits leave through an output latch that can only pull the data line low.

The controlling logic reads the flags, the shift register and the counter. It can load the shift register, preload the counter and clear flags. Clearing a flag is also how it releases a held clock. Address matching, acknowledge decisions and byte sequencing belong to the controlling logic. The unit stretches the clock so that this logic has time to act. It holds the clock after a start, once the master pulls the clock low, and after every counter overflow.

A four-state machine decides the clock hold:
- `ST_IDLE`: no hold. It goes to `ST_OVF_HOLD` on a counter overflow.
- `ST_ARMED`: a start has been seen. It goes to `ST_START_HOLD` on the next clock falling edge, or back to `ST_IDLE` if the start flag is cleared first.
- `ST_START_HOLD`: the clock is held low. It goes to `ST_IDLE` when the start flag is cleared.
- `ST_OVF_HOLD`: the clock is held low. It goes to `ST_IDLE` when the overflow flag is cleared.

From any state, a start goes to `ST_ARMED` and a low mode enable goes to `ST_IDLE`.

Top module: `twi_slave_shifter`

## Requirements
- R1: After reset, all three flags and `irq` are 0, neither line is pulled low, `cnt_q` is 0 and `shift_q` is all ones.
- R2: With `en` high, a falling edge of the data line while the clock line is high sets `start_flag`, and `irq` follows it.
- R3: After a start, `scl_drive_low` goes to 1 once the master pulls the clock low. It stays 1 until `clr_start` is pulsed. The `clr_start` pulse also resets `cnt_q` to 0.
- R4: On each clock rising edge the data-line value enters `shift_q` at bit 0, and the register moves toward the MSB. After eight bits, `shift_q` holds the byte sent MSB first.
- R5: `cnt_q` advances by one on every clock edge, rising or falling. An edge at count 15 wraps the counter to 0 and sets `ovf_flag`. From then `scl_drive_low` stays 1, even if the master releases the clock, until `clr_ovf` is pulsed.
- R6: Preloading `cnt_q` with 14 (`wr_cnt` with `cnt_wdata` = 14) makes the next overflow come after exactly one bit, that is, two edges.
- R7: `sda_drive_low` is 1 only when `sda_oe` is 1 and the output bit is 0. The output bit takes bit 7 of `shift_wdata` on `wr_shift`. On each clock falling edge it takes bit 7 of `shift_q`. Loading a byte therefore sends it MSB first.
- R8: A rising edge of the data line while the clock line is high sets `stop_flag` and does not hold the clock.
- R9: With `en` low, start and stop conditions set no flag, and no clock hold begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Two-wire mode enable |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_drive_low | output | 1 | Pulls the clock line low when 1 |
| sda_drive_low | output | 1 | Pulls the data line low when 1 |
| sda_oe | input | 1 | Lets the output bit reach the data line |
| wr_shift | input | 1 | Loads `shift_wdata` into the shift register |
| shift_wdata | input | DATA_W | Shift register load value |
| wr_cnt | input | 1 | Loads `cnt_wdata` into the edge counter |
| cnt_wdata | input | CNT_W | Edge counter load value |
| clr_start | input | 1 | Clears the start flag and the counter |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_stop | input | 1 | Clears the stop flag |
| shift_q | output | DATA_W | Shift register contents |
| cnt_q | output | CNT_W | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter overflowed |
| stop_flag | output | 1 | Stop condition seen |
| irq | output | 1 | Start or overflow flag set |

## Verification
The bench uses the default parameters: an 8-bit shift register, a 4-bit counter and two synchroniser stages. With these values all 256 byte values can be swept. For each byte the bench runs a full transaction: start, a received byte, an acknowledge with the counter preloaded, the bitwise complement sent back, then stop. Along the way it visits every state of the hold machine and every wrap of the counter. A 6-cycle bus phase keeps the clock well under a quarter of the system rate, so the synchroniser latency stays inside each phase.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START_HOLD,
        ST_OVF_HOLD
    } hold_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_prev;
    logic sda_late;
    logic sda_late_prev;

    // SDA is looked at one cycle later than SCL, so SCL is stable around it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev      <= 1'b1;
            sda_late      <= 1'b1;
            sda_late_prev <= 1'b1;
        end else begin
            scl_prev      <= scl_s;
            sda_late      <= sda_s;
            sda_late_prev <= sda_late;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_evt = en & scl_s & sda_late_prev & ~sda_late;
    assign stop_evt  = en & scl_s & ~sda_late_prev & sda_late;
endmodule

// File: rtl/twi_shift_cnt.sv
module twi_shift_cnt #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              wr_shift,
    input  logic [DATA_W-1:0] shift_wdata,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cnt_clr,
    output logic [DATA_W-1:0] shift_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              out_bit,
    output logic              ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic edge_seen;
    assign edge_seen = en & (scl_rise | scl_fall);
    assign ovf_evt   = edge_seen & ~wr_cnt & ~cnt_clr & (cnt_q == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (wr_cnt)    cnt_q <= cnt_wdata;
        else if (cnt_clr)   cnt_q <= '0;
        else if (edge_seen) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              shift_q <= '1;
        else if (wr_shift)       shift_q <= shift_wdata;
        else if (en && scl_rise) shift_q <= {shift_q[DATA_W-2:0], sda_s};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              out_bit <= 1'b1;
        else if (wr_shift)       out_bit <= shift_wdata[DATA_W-1];
        else if (en && scl_fall) out_bit <= shift_q[DATA_W-1];
    end
endmodule

// File: rtl/twi_hold_fsm.sv
module twi_hold_fsm
    import twi_slave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_evt,
    input  logic scl_fall,
    input  logic ovf_evt,
    input  logic clr_start,
    input  logic clr_ovf,
    output logic hold
);
    hold_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:       if (ovf_evt) state_nx = ST_OVF_HOLD;
                ST_ARMED: begin
                    if (clr_start)     state_nx = ST_IDLE;
                    else if (scl_fall) state_nx = ST_START_HOLD;
                end
                ST_START_HOLD: if (clr_start) state_nx = ST_IDLE;
                ST_OVF_HOLD:   if (clr_ovf)   state_nx = ST_IDLE;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        hold = (state == ST_START_HOLD) || (state == ST_OVF_HOLD);
    end
endmodule

// File: rtl/twi_slave_shifter.sv
module twi_slave_shifter #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_oe,
    input  logic              wr_shift,
    input  logic [DATA_W-1:0] shift_wdata,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              clr_start,
    input  logic              clr_ovf,
    input  logic              clr_stop,
    output logic [DATA_W-1:0] shift_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag,
    output logic              irq
);
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;
    logic ovf_evt, out_bit, hold;

    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
    );
    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
    );

    twi_bus_cond i_cond (
        .clk(clk), .rst_n(rst_n), .en(en), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_shift_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_datapath (
        .clk(clk), .rst_n(rst_n), .en(en),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .wr_shift(wr_shift), .shift_wdata(shift_wdata),
        .wr_cnt(wr_cnt), .cnt_wdata(cnt_wdata), .cnt_clr(clr_start),
        .shift_q(shift_q), .cnt_q(cnt_q), .out_bit(out_bit), .ovf_evt(ovf_evt)
    );

    twi_hold_fsm i_hold (
        .clk(clk), .rst_n(rst_n), .en(en), .start_evt(start_evt),
        .scl_fall(scl_fall), .ovf_evt(ovf_evt),
        .clr_start(clr_start), .clr_ovf(clr_ovf), .hold(hold)
    );

    // setting a flag wins over clearing it in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            ovf_flag   <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            start_flag <= start_evt | (start_flag & ~clr_start);
            ovf_flag   <= ovf_evt   | (ovf_flag   & ~clr_ovf);
            stop_flag  <= stop_evt  | (stop_flag  & ~clr_stop);
        end
    end

    assign scl_drive_low = hold;
    assign sda_drive_low = sda_oe & ~out_bit;
    assign irq           = start_flag | ovf_flag;
endmodule

// File: rtl/twi_slave_shifter_chk.sv
module twi_slave_shifter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             start_evt,
    input logic             start_flag,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] cnt_q,
    input logic             scl_drive_low
);
    AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> start_flag);                                  // R2
    AST_HOLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> (start_flag || ovf_flag));                // R3
    AST_OVF_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt_q == '0));                         // R5
    AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(start_flag));                                // R9
endmodule

bind twi_slave_shifter twi_slave_shifter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .start_evt(start_evt),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .cnt_q(cnt_q),
    .scl_drive_low(scl_drive_low)
);

// File: tb/test_twi_slave_shifter.sv
`timescale 1ns/1ps
module test_twi_slave_shifter;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int PH = 6;
    localparam logic [CW-1:0] ACK_PRE = CW'((1 << CW) - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_drive_low, sda_drive_low;
    logic sda_oe = 1'b0, wr_shift = 1'b0, wr_cnt = 1'b0;
    logic clr_start = 1'b0, clr_ovf = 1'b0, clr_stop = 1'b0;
    logic [DW-1:0] shift_wdata = '0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [DW-1:0] shift_q;
    logic [CW-1:0] cnt_q;
    logic start_flag, ovf_flag, stop_flag, irq;
    logic scl_bus, sda_bus;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_drive_low;
    assign sda_bus = sda_m & ~sda_drive_low;

    twi_slave_shifter i_twi_slave_shifter (
        .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_oe(sda_oe), .wr_shift(wr_shift), .shift_wdata(shift_wdata),
        .wr_cnt(wr_cnt), .cnt_wdata(cnt_wdata), .clr_start(clr_start),
        .clr_ovf(clr_ovf), .clr_stop(clr_stop), .shift_q(shift_q),
        .cnt_q(cnt_q), .start_flag(start_flag), .ovf_flag(ovf_flag),
        .stop_flag(stop_flag), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clock_bit(input logic bit_in, output logic seen);
        sda_m = bit_in;
        step(PH);
        scl_m = 1'b1;
        step(PH);
        seen = sda_bus;
        scl_m = 1'b0;
        step(PH);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 flags", {29'd0, start_flag, ovf_flag, stop_flag}, 32'd0);
        check("R1 drive", {30'd0, scl_drive_low, sda_drive_low}, 32'd0);
        check("R1 cnt", 32'(cnt_q), 32'd0);
        check("R1 shift", 32'(shift_q), 32'hFF);
        check("R1 irq", 32'(irq), 32'd0);

        for (int b = 0; b < 256; b++) begin
            logic [DW-1:0] tx, rx;
            logic seen;
            tx = ~DW'(b);
            // start condition
            sda_m = 1'b0;
            step(PH);
            check("R2 start_flag", 32'(start_flag), 32'd1);
            check("R2 irq", 32'(irq), 32'd1);
            scl_m = 1'b0;
            step(PH);
            check("R3 start hold", 32'(scl_drive_low), 32'd1);
            clr_start = 1'b1; step(1); clr_start = 1'b0;
            step(1);
            check("R3 hold released", 32'(scl_drive_low), 32'd0);
            check("R3 cnt cleared", 32'(cnt_q), 32'd0);
            // receive byte MSB first
            for (int i = DW - 1; i >= 0; i--) clock_bit(b[i], seen);
            check("R4 received byte", 32'(shift_q), 32'(b));
            check("R5 ovf_flag", 32'(ovf_flag), 32'd1);
            check("R5 cnt wrapped", 32'(cnt_q), 32'd0);
            sda_m = 1'b1;
            scl_m = 1'b1;
            step(PH);
            check("R5 clock held", 32'(scl_bus), 32'd0);
            // acknowledge through preload
            wr_shift = 1'b1; shift_wdata = '0; wr_cnt = 1'b1; cnt_wdata = ACK_PRE;
            sda_oe = 1'b1;
            step(1);
            wr_shift = 1'b0; wr_cnt = 1'b0;
            step(1);
            clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
            step(PH);
            check("R7 ack drives low", 32'(sda_bus), 32'd0);
            check("R6 cnt after rise", 32'(cnt_q), 32'(ACK_PRE) + 1);
            scl_m = 1'b0;
            step(PH);
            check("R6 ovf after one bit", 32'(ovf_flag), 32'd1);
            check("R6 held", 32'(scl_drive_low), 32'd1);
            // slave transmits complement
            wr_shift = 1'b1; shift_wdata = tx; step(1); wr_shift = 1'b0;
            step(1);
            clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
            rx = '0;
            for (int i = DW - 1; i >= 0; i--) begin
                clock_bit(1'b1, seen);
                rx[i] = seen;
            end
            check("R7 transmitted byte", 32'(rx), 32'(tx));
            check("R5 ovf after tx", 32'(ovf_flag), 32'd1);
            // stop condition
            sda_oe = 1'b0;
            sda_m = 1'b0;
            step(PH);
            clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
            scl_m = 1'b1;
            step(PH);
            sda_m = 1'b1;
            step(PH);
            check("R8 stop_flag", 32'(stop_flag), 32'd1);
            check("R8 no hold", 32'(scl_drive_low), 32'd0);
            clr_stop = 1'b1; step(1); clr_stop = 1'b0;
            step(1);
        end

        // R9 disabled mode
        en = 1'b0;
        step(2);
        sda_m = 1'b0;
        step(PH);
        check("R9 no start", 32'(start_flag), 32'd0);
        scl_m = 1'b0;
        step(PH);
        check("R9 no hold", 32'(scl_drive_low), 32'd0);
        scl_m = 1'b1;
        step(PH);
        sda_m = 1'b1;
        step(PH);
        check("R9 no stop", 32'(stop_flag), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule